// File: doc/BRIEF.md
# Secure Gateway Call-Return Controller

This controller sits beside an instruction-fetch stage and decides, one instruction at a time, whether execution is in the Secure or the Non-Secure domain. Each fetched instruction arrives as one beat. The beat carries the instruction address, the security attribute of the memory that holds it, its opcode, and a flow field that says what kind of branch the instruction makes and where it goes. The controller lets Non-Secure code reach Secure memory only through a gateway opcode that sits in callable memory. It hides the return address of a Secure-to-Non-Secure call inside an internal return-address stack. When Non-Secure code branches to the return marker, it sends execution back to the hidden address.

All outputs are registered and change on the clock edge that accepts a beat. Fault, push, pop and redirect outputs are single-cycle pulses. The instruction stream is a valid/ready input. A beat is taken on a rising edge where `fetch_valid` and `fetch_ready` are both high. When `fetch_ready` is low, upstream must hold the beat unchanged. `fetch_ready` drops for exactly one cycle after any fault or redirect, so the fetch stage can flush and steer. In every other cycle it is high.

Top module: `sgc_ctrl`

## Requirements
- R1: After reset, `sec_state` is 1 when the security extension is present (HAS_SEC=1), `fetch_ready` is 1, every pulse output is 0 and the return stack is empty.
- R2: For an accepted beat that makes no domain branch, the next `sec_state` follows the beat's attribute. The attribute codes are 0 = Non-Secure, 1 = Secure, 2 = callable Secure and 3 = Secure. So code 0 gives 0 and any other code gives 1, except in the entry cases of R3 and R4.
- R3: While `sec_state` is 0, a beat with attribute 2 whose opcode equals GATE_OP is accepted and sets `sec_state` to 1 with no fault.
- R4: While `sec_state` is 0, any beat in Secure memory that is not the gateway case of R3 pulses `fault_req` and leaves `sec_state` at 0. This includes GATE_OP found in attribute 1.
- R5: `fault_excnum` is 7 when FULL_FAULT=1 and 3 (a hard fault) when FULL_FAULT=0.
- R6: A flow code 2 (return to Non-Secure) in Secure code sets `sec_state` to `br_target[0]`. A cleared bit means Non-Secure and a set bit keeps Secure.
- R7: A flow code 3 (call to Non-Secure) in Secure code pushes `fetch_addr + INSN_BYTES` and pulses `push_req` with that value on `push_addr`. It also pulses `lr_load` with `lr_value` = RET_MARK, and sets `sec_state` to `br_target[0]`.
- R8: A flow code 1 (plain branch) from Non-Secure code with `br_target` = RET_MARK pops the stack and pulses `pop_req` and `redirect_valid`. `redirect_addr` is the most recently pushed address, in last-in first-out order, and `sec_state` becomes 1.
- R9: A branch to RET_MARK while the stack is empty pulses `fault_req`, with no pop and no redirect, and `sec_state` stays 0.
- R10: A call to Non-Secure while the stack holds DEPTH entries pulses `fault_req`, with no push and no `lr_load`, and `sec_state` stays 1.
- R11: With HAS_SEC=0, `sec_state` is always 0 and no fault, push or pop is ever raised.
- R12: `fetch_ready` is 0 for exactly the one cycle after a fault or redirect pulse. A beat presented then is held and taken once on the next cycle.
- R13: Flow codes 2 and 3 in Non-Secure code, and the flow field of a faulting beat, have no effect: no push, no `lr_load`, and no change of state beyond R2 or R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Instruction beat present |
| fetch_ready | output | 1 | Beat can be taken this cycle |
| fetch_addr | input | AW | Address of the instruction |
| fetch_attr | input | 2 | Memory attribute of the instruction: 0 Non-Secure, 1 Secure, 2 callable, 3 Secure |
| fetch_op | input | OPW | Instruction opcode |
| br_kind | input | 2 | Flow code: 0 none, 1 plain branch, 2 return to Non-Secure, 3 call to Non-Secure |
| br_target | input | AW | Branch target; bit 0 selects the domain for flow codes 2 and 3 |
| sec_state | output | 1 | Current domain, 1 = Secure |
| fault_req | output | 1 | Security fault pulse |
| fault_excnum | output | 4 | Exception number of the fault |
| push_req | output | 1 | Return address pushed |
| push_addr | output | AW | Address that was pushed |
| pop_req | output | 1 | Return address popped |
| redirect_valid | output | 1 | Resume pulse after unstacking |
| redirect_addr | output | AW | Secure address to resume at |
| lr_load | output | 1 | Link value must be replaced |
| lr_value | output | AW | Return marker to load into the link value |

## Verification
Instance u0 is built with DEPTH=2 and FULL_FAULT=1, so the stack fills after two nested calls. This brings the overflow fault and last-in first-out unwinding into a short run. Instance u2 shares that stack depth but sets FULL_FAULT=0, which shows the hard-fault number on the same faults. Instance u1 sets HAS_SEC=0 and receives the same stream, which shows that the domain never leaves Non-Secure. All three keep a 32-bit address, a 16-bit opcode, gateway opcode 16'hA5C3 and return marker 32'hFFFF_FF10.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  typedef enum logic [1:0] {
    MEM_NS  = 2'd0,
    MEM_S   = 2'd1,
    MEM_NSC = 2'd2,
    MEM_RSV = 2'd3
  } mem_attr_e;

  typedef enum logic [1:0] {
    FLOW_NONE    = 2'd0,
    FLOW_BR      = 2'd1,
    FLOW_TO_NS   = 2'd2,
    FLOW_CALL_NS = 2'd3
  } flow_e;

  localparam logic [3:0] EXC_SECURE = 4'd7;
  localparam logic [3:0] EXC_HARD   = 4'd3;

endpackage

// File: rtl/sgc_entry_chk.sv
module sgc_entry_chk
  import sgc_pkg::*;
#(
  parameter int OPW = 16,
  parameter logic [OPW-1:0] GATE_OP = 16'hA5C3
) (
  input  logic           cur_sec,
  input  logic [1:0]     attr,
  input  logic [OPW-1:0] op,
  output logic           enter_ok,
  output logic           enter_bad
);
  logic into_sec;

  always_comb begin
    into_sec  = !cur_sec && (mem_attr_e'(attr) != MEM_NS);
    enter_ok  = into_sec && (mem_attr_e'(attr) == MEM_NSC) && (op == GATE_OP);
    enter_bad = into_sec && !enter_ok;
  end
endmodule

// File: rtl/sgc_flow.sv
module sgc_flow
  import sgc_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RET_MARK = 32'hFFFF_FF10
) (
  input  logic [1:0]    attr,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] target,
  input  logic          stk_full,
  input  logic          stk_empty,
  output logic          want_push,
  output logic          want_pop,
  output logic          stk_fault,
  output logic          next_sec
);
  logic exec_sec;

  always_comb begin
    exec_sec  = (mem_attr_e'(attr) != MEM_NS);
    want_push = 1'b0;
    want_pop  = 1'b0;
    stk_fault = 1'b0;
    next_sec  = exec_sec;
    if (exec_sec) begin
      case (flow_e'(kind))
        FLOW_CALL_NS: begin
          if (stk_full) stk_fault = 1'b1;
          else begin
            want_push = 1'b1;
            next_sec  = target[0];
          end
        end
        FLOW_TO_NS: next_sec = target[0];
        default: ;
      endcase
    end else if (flow_e'(kind) == FLOW_BR && target == RET_MARK) begin
      if (stk_empty) stk_fault = 1'b1;
      else begin
        want_pop = 1'b1;
        next_sec = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgc_ret_stack.sv
module sgc_ret_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] top,
  output logic          full,
  output logic          empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [IW-1:0] wr_idx, rd_idx;

  always_comb begin
    full   = (cnt == CW'(DEPTH));
    empty  = (cnt == '0);
    wr_idx = IW'(cnt);
    rd_idx = empty ? '0 : IW'(cnt - 1'b1);
    top    = mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (push && !full) cnt <= cnt + 1'b1;
    else if (pop && !empty) cnt <= cnt - 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[g] <= '0;
        else if (push && !full && wr_idx == IW'(g)) mem[g] <= wdata;
      end
    end
  endgenerate

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/sgc_ctrl.sv
module sgc_ctrl
  import sgc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int OPW        = 16,
  parameter int DEPTH      = 4,
  parameter int HAS_SEC    = 1,
  parameter int FULL_FAULT = 1,
  parameter int INSN_BYTES = 4,
  parameter logic [OPW-1:0] GATE_OP  = 16'hA5C3,
  parameter logic [AW-1:0]  RET_MARK = 32'hFFFF_FF10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_valid,
  output logic           fetch_ready,
  input  logic [AW-1:0]  fetch_addr,
  input  logic [1:0]     fetch_attr,
  input  logic [OPW-1:0] fetch_op,
  input  logic [1:0]     br_kind,
  input  logic [AW-1:0]  br_target,
  output logic           sec_state,
  output logic           fault_req,
  output logic [3:0]     fault_excnum,
  output logic           push_req,
  output logic [AW-1:0]  push_addr,
  output logic           pop_req,
  output logic           redirect_valid,
  output logic [AW-1:0]  redirect_addr,
  output logic           lr_load,
  output logic [AW-1:0]  lr_value
);
  localparam logic SEC_ON = (HAS_SEC != 0);

  logic          sec_q, rdy_q, fault_q, push_q, pop_q;
  logic [AW-1:0] push_addr_q, redir_addr_q;
  logic          accept, enter_ok, enter_bad;
  logic          want_push, want_pop, stk_fault, next_sec;
  logic          stk_full, stk_empty, stk_push, stk_pop, fault_n;
  logic [AW-1:0] stk_top, ret_addr;

  sgc_entry_chk #(.OPW(OPW), .GATE_OP(GATE_OP)) u_entry (
    .cur_sec(sec_q), .attr(fetch_attr), .op(fetch_op),
    .enter_ok(enter_ok), .enter_bad(enter_bad)
  );

  sgc_flow #(.AW(AW), .RET_MARK(RET_MARK)) u_flow (
    .attr(fetch_attr), .kind(br_kind), .target(br_target),
    .stk_full(stk_full), .stk_empty(stk_empty),
    .want_push(want_push), .want_pop(want_pop),
    .stk_fault(stk_fault), .next_sec(next_sec)
  );

  sgc_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
    .wdata(ret_addr), .top(stk_top), .full(stk_full), .empty(stk_empty)
  );

  always_comb begin
    accept   = fetch_valid && rdy_q;
    ret_addr = fetch_addr + AW'(INSN_BYTES);
    fault_n  = SEC_ON && accept && (enter_bad || stk_fault);
    stk_push = SEC_ON && accept && !enter_bad && want_push;
    stk_pop  = SEC_ON && accept && !enter_bad && want_pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q        <= SEC_ON;
      rdy_q        <= 1'b1;
      fault_q      <= 1'b0;
      push_q       <= 1'b0;
      pop_q        <= 1'b0;
      push_addr_q  <= '0;
      redir_addr_q <= '0;
    end else begin
      fault_q <= fault_n;
      push_q  <= stk_push;
      pop_q   <= stk_pop;
      rdy_q   <= !(fault_n || stk_pop);
      if (stk_push) push_addr_q <= ret_addr;
      if (stk_pop)  redir_addr_q <= stk_top;
      if (accept && !fault_n) sec_q <= SEC_ON && next_sec;
    end
  end

  generate
    if (FULL_FAULT != 0) begin : g_full
      assign fault_excnum = EXC_SECURE;
    end else begin : g_base
      assign fault_excnum = EXC_HARD;
    end
  endgenerate

  assign fetch_ready    = rdy_q;
  assign sec_state      = sec_q;
  assign fault_req      = fault_q;
  assign push_req       = push_q;
  assign push_addr      = push_addr_q;
  assign pop_req        = pop_q;
  assign redirect_valid = pop_q;
  assign redirect_addr  = redir_addr_q;
  assign lr_load        = push_q;
  assign lr_value       = RET_MARK;

  // R3
  gate_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_state) |-> redirect_valid ||
      ($past(fetch_attr) == MEM_NSC && $past(fetch_op) == GATE_OP));

  // R8
  unstack_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> sec_state && $past(br_target) == RET_MARK);

  generate
    if (!SEC_ON) begin : g_nosec_chk
      // R11
      stay_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_state && !fault_req && !push_req && !pop_req);
    end
  endgenerate
endmodule

// File: tb/sim_sgc_ctrl.sv
module sim_sgc_ctrl;
  localparam logic [15:0] GATE = 16'hA5C3;
  localparam logic [31:0] MARK = 32'hFFFF_FF10;

  typedef struct packed {
    logic [1:0]  attr;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [15:0] op;
    logic [31:0] tgt;
    logic        e_sec;
    logic [3:0]  e_flg;   // {fault, push, pop, lr}
    logic [31:0] e_redir;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 2'd0, 32'h1000, 16'h0000, 32'h0,    1'b1, 4'b0000, 32'h0},    // R2
    '{2'd1, 2'd2, 32'h1004, 16'h0000, 32'h2001, 1'b1, 4'b0000, 32'h0},    // R6
    '{2'd1, 2'd2, 32'h1008, 16'h0000, 32'h2000, 1'b0, 4'b0000, 32'h0},    // R6
    '{2'd0, 2'd0, 32'h2000, 16'h0000, 32'h0,    1'b0, 4'b0000, 32'h0},    // R2
    '{2'd1, 2'd3, 32'h3000, GATE,     32'h6000, 1'b0, 4'b1000, 32'h0},    // R4 R13
    '{2'd2, 2'd0, 32'h4000, 16'h0000, 32'h0,    1'b0, 4'b1000, 32'h0},    // R4 R12
    '{2'd2, 2'd0, 32'h4004, GATE,     32'h0,    1'b1, 4'b0000, 32'h0},    // R3
    '{2'd1, 2'd3, 32'h5000, 16'h0000, 32'h6000, 1'b0, 4'b0101, 32'h0},    // R7
    '{2'd0, 2'd3, 32'h6000, 16'h0000, 32'h0,    1'b0, 4'b0000, 32'h0},    // R13
    '{2'd0, 2'd1, 32'h6004, 16'h0000, MARK,     1'b1, 4'b0010, 32'h5004}, // R8
    '{2'd1, 2'd0, 32'h5004, 16'h0000, 32'h0,    1'b1, 4'b0000, 32'h0},    // R12
    '{2'd0, 2'd0, 32'h7000, 16'h0000, 32'h0,    1'b0, 4'b0000, 32'h0},    // R2
    '{2'd0, 2'd1, 32'h7004, 16'h0000, MARK,     1'b0, 4'b1000, 32'h0},    // R9
    '{2'd2, 2'd0, 32'h4008, GATE,     32'h0,    1'b1, 4'b0000, 32'h0},    // R3
    '{2'd1, 2'd3, 32'h5100, 16'h0000, 32'h6001, 1'b1, 4'b0101, 32'h0},    // R7
    '{2'd1, 2'd3, 32'h5200, 16'h0000, 32'h6001, 1'b1, 4'b0101, 32'h0},    // R7
    '{2'd1, 2'd3, 32'h5300, 16'h0000, 32'h6000, 1'b1, 4'b1000, 32'h0},    // R10
    '{2'd1, 2'd2, 32'h5304, 16'h0000, 32'h6000, 1'b0, 4'b0000, 32'h0},    // R6
    '{2'd0, 2'd1, 32'h6000, 16'h0000, MARK,     1'b1, 4'b0010, 32'h5204}, // R8
    '{2'd1, 2'd2, 32'h5204, 16'h0000, 32'h6000, 1'b0, 4'b0000, 32'h0},    // R6
    '{2'd0, 2'd1, 32'h6008, 16'h0000, MARK,     1'b1, 4'b0010, 32'h5104}, // R8
    '{2'd1, 2'd0, 32'h5104, 16'h0000, 32'h0,    1'b1, 4'b0000, 32'h0}     // R2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic [1:0]  fetch_attr = '0;
  logic [15:0] fetch_op = '0;
  logic [1:0]  br_kind = '0;
  logic [31:0] br_target = '0;

  logic        rdy0, sec0, flt0, psh0, pop0, rv0, lr0;
  logic [3:0]  exc0;
  logic [31:0] pa0, ra0, lv0;
  logic        rdy1, sec1, flt1, psh1, pop1, rv1, lr1;
  logic [3:0]  exc1;
  logic [31:0] pa1, ra1, lv1;
  logic        rdy2, sec2, flt2, psh2, pop2, rv2, lr2;
  logic [3:0]  exc2;
  logic [31:0] pa2, ra2, lv2;

  int checks = 0;
  int errors = 0;
  int pushes = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sgc_ctrl #(.DEPTH(2), .HAS_SEC(1), .FULL_FAULT(1)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(rdy0),
    .fetch_addr(fetch_addr), .fetch_attr(fetch_attr), .fetch_op(fetch_op),
    .br_kind(br_kind), .br_target(br_target), .sec_state(sec0),
    .fault_req(flt0), .fault_excnum(exc0), .push_req(psh0), .push_addr(pa0),
    .pop_req(pop0), .redirect_valid(rv0), .redirect_addr(ra0),
    .lr_load(lr0), .lr_value(lv0));

  sgc_ctrl #(.DEPTH(2), .HAS_SEC(0), .FULL_FAULT(1)) u1 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(rdy1),
    .fetch_addr(fetch_addr), .fetch_attr(fetch_attr), .fetch_op(fetch_op),
    .br_kind(br_kind), .br_target(br_target), .sec_state(sec1),
    .fault_req(flt1), .fault_excnum(exc1), .push_req(psh1), .push_addr(pa1),
    .pop_req(pop1), .redirect_valid(rv1), .redirect_addr(ra1),
    .lr_load(lr1), .lr_value(lv1));

  sgc_ctrl #(.DEPTH(2), .HAS_SEC(1), .FULL_FAULT(0)) u2 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(rdy2),
    .fetch_addr(fetch_addr), .fetch_attr(fetch_attr), .fetch_op(fetch_op),
    .br_kind(br_kind), .br_target(br_target), .sec_state(sec2),
    .fault_req(flt2), .fault_excnum(exc2), .push_req(psh2), .push_addr(pa2),
    .pop_req(pop2), .redirect_valid(rv2), .redirect_addr(ra2),
    .lr_load(lr2), .lr_value(lv2));

  always @(posedge clk) if (psh0) pushes <= pushes + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the beat is taken
  task automatic beat(input logic [1:0] a, input logic [1:0] k, input logic [31:0] ad,
                      input logic [15:0] o, input logic [31:0] t);
    fetch_valid = 1'b1; fetch_attr = a; br_kind = k;
    fetch_addr = ad; fetch_op = o; br_target = t;
    while (!rdy0) @(negedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic reset_pulse();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    reset_pulse();
    // R1 reset state
    check("R1 sec_state", 32'(sec0), 32'd1);
    check("R1 fetch_ready", 32'(rdy0), 32'd1);
    check("R1 pulses", 32'({flt0, psh0, pop0, rv0, lr0}), 32'd0);
    check("R11 sec_state reset", 32'(sec1), 32'd0);

    for (int i = 0; i < NV; i++) begin
      beat(VEC[i].attr, VEC[i].kind, VEC[i].addr, VEC[i].op, VEC[i].tgt);
      check($sformatf("R2 state vec %0d", i), 32'(sec0), 32'(VEC[i].e_sec));
      check($sformatf("R4 fault vec %0d", i), 32'(flt0), 32'(VEC[i].e_flg[3]));
      check($sformatf("R7 push vec %0d", i), 32'(psh0), 32'(VEC[i].e_flg[2]));
      check($sformatf("R8 pop vec %0d", i), 32'(pop0), 32'(VEC[i].e_flg[1]));
      check($sformatf("R7 lr_load vec %0d", i), 32'(lr0), 32'(VEC[i].e_flg[0]));
      check($sformatf("R12 ready vec %0d", i), 32'(rdy0),
            32'(!(VEC[i].e_flg[3] || VEC[i].e_flg[1])));
      if (VEC[i].e_flg[2]) begin
        check($sformatf("R7 push_addr vec %0d", i), pa0, VEC[i].addr + 32'd4);
        check($sformatf("R7 lr_value vec %0d", i), lv0, MARK);
      end
      if (VEC[i].e_flg[1]) begin
        check($sformatf("R8 redirect_valid vec %0d", i), 32'(rv0), 32'd1);
        check($sformatf("R8 redirect_addr vec %0d", i), ra0, VEC[i].e_redir);
      end
      if (VEC[i].e_flg[3]) begin
        check($sformatf("R5 secure fault code vec %0d", i), 32'(exc0), 32'd7);
        check($sformatf("R5 hard fault code vec %0d", i), 32'(exc2), 32'd3);
        check($sformatf("R5 reduced fault pulse vec %0d", i), 32'(flt2), 32'd1);
      end
      check($sformatf("R11 no-ext vec %0d", i),
            32'({sec1, flt1, psh1, pop1}), 32'd0);
    end
    // R12 held beats taken once: three pushes in total
    check("R12 push count", 32'(pushes), 32'd3);

    // R1 reset clears the stack: leave Secure then branch to the marker
    reset_pulse();
    check("R1 sec_state after second reset", 32'(sec0), 32'd1);
    beat(2'd1, 2'd2, 32'h1000, 16'h0, 32'h2000);
    check("R6 leave Secure", 32'(sec0), 32'd0);
    beat(2'd0, 2'd1, 32'h2000, 16'h0, MARK);
    check("R1 stack empty after reset", 32'(flt0), 32'd1);
    check("R9 no redirect on empty", 32'(rv0), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule